// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked-Write Shadow Registers

This block is a single eight-pin general-purpose I/O port behind a small memory-mapped register interface. Three writable registers decide, per pin, whether the pin is under GPIO control (mode), whether it drives the pad (direction) and what value it drives. A fourth, read-only register returns the pad levels after a two-flop synchronizer.

Every register also answers at a second, shadow address, a fixed parameterised distance above its plain address. A write there carries a per-pin mask in data bits [15:8] and the new pin values in bits [7:0]. Only pins whose mask bit is set change, so software can flip a single pin without a read-modify-write. Several agents can share the port this way without any locking.

A pin whose mode bit is 0 never drives its pad, whatever its direction bit holds. The mode bits are also brought out so that a pad multiplexer can hand the pin to another function.

Top module: `gpio_mw_port`

## Requirements
- R1: While reset is asserted and after its release, the mode, direction and output-value registers are all 0. As a result, pad_oe_o, pad_out_o, gpio_en_o and rdata_o are all 0.
- R2: A plain write stores wdata_i[7:0] in the addressed register. The register offsets are 0x000 for mode, 0x010 for direction and 0x020 for output value. The new value appears on the outputs in the cycle after the write request.
- R3: A write at MASK_OFS plus a register offset changes only the pins whose bit in wdata_i[15:8] is 1, setting each of them to the matching bit of wdata_i[7:0]. A mask of 0 leaves the register unchanged.
- R4: pad_out_o equals the output-value register, gpio_en_o equals the mode register, and pad_oe_o is the direction register ANDed with the mode register. A pin with mode bit 0 therefore never drives its pad.
- R5: The input register at offset 0x030 returns pad_in_i through two flops. A read issued in the same cycle as a pad change still returns the previous level.
- R6: Writes to the input register (0x030 or MASK_OFS+0x030) and writes to unmapped addresses change no state.
- R7: A read loads rdata_o one cycle after the request, zero-extended from 8 bits, and rdata_o holds its value when there is no read. A read at a masked-write address returns the plain register, and a read at an unmapped address returns 0.
- R8: Write data bits [31:16] are ignored at every address. Bits [15:8] are also ignored by plain writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (12) | Byte address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, registered |
| pad_in_i | input | PIN_W (8) | Pad input levels, asynchronous |
| pad_out_o | output | PIN_W (8) | Pad output values |
| pad_oe_o | output | PIN_W (8) | Pad output enables |
| gpio_en_o | output | PIN_W (8) | Per-pin GPIO mode, for the pad multiplexer |

## Verification
The bench builds the port with its defaults: eight pins, a 12-bit address, the shadow window at 0x080 and two synchronizer stages. With the shadow window this close, the plain and masked addresses of the same register differ in a single address bit, so a decode that ignored that bit would be caught by both the masked and the plain sequences. Two stages make the one-read lag on a freshly changed pad directly observable. A reference model checks every pad output and the read data on every clock.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_DIR,
    SEL_OUT,
    SEL_IN
  } sel_e;

  localparam int unsigned OFS_MODE = 'h000;
  localparam int unsigned OFS_DIR  = 'h010;
  localparam int unsigned OFS_OUT  = 'h020;
  localparam int unsigned OFS_IN   = 'h030;
  localparam int unsigned N_WREG   = 3;

  function automatic sel_e wreg_sel(input int unsigned idx);
    case (idx)
      0:       return SEL_MODE;
      1:       return SEL_DIR;
      default: return SEL_OUT;
    endcase
  endfunction
endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
  import gpio_mw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned MASK_OFS = 'h080
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o,
  output logic              masked_o
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_OUT   = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_IN    = ADDR_W'(OFS_IN);
  localparam logic [ADDR_W-1:0] M_MODE  = ADDR_W'(MASK_OFS + OFS_MODE);
  localparam logic [ADDR_W-1:0] M_DIR   = ADDR_W'(MASK_OFS + OFS_DIR);
  localparam logic [ADDR_W-1:0] M_OUT   = ADDR_W'(MASK_OFS + OFS_OUT);
  localparam logic [ADDR_W-1:0] M_IN    = ADDR_W'(MASK_OFS + OFS_IN);

  always_comb begin
    sel_o    = SEL_NONE;
    masked_o = 1'b0;
    unique case (addr_i)
      A_MODE:  sel_o = SEL_MODE;
      A_DIR:   sel_o = SEL_DIR;
      A_OUT:   sel_o = SEL_OUT;
      A_IN:    sel_o = SEL_IN;
      M_MODE:  begin sel_o = SEL_MODE; masked_o = 1'b1; end
      M_DIR:   begin sel_o = SEL_DIR;  masked_o = 1'b1; end
      M_OUT:   begin sel_o = SEL_OUT;  masked_o = 1'b1; end
      M_IN:    begin sel_o = SEL_IN;   masked_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_mw_bitreg.sv
module gpio_mw_bitreg #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           masked_i,
  input  logic [2*W-1:0] wdata_i,
  output logic [W-1:0]   q_o
);
  logic [W-1:0] keep_n;

  // plain write: every bit takes the new value
  assign keep_n = masked_i ? wdata_i[2*W-1:W] : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= (q_o & ~keep_n) | (wdata_i[W-1:0] & keep_n);
  end
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
#(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned MASK_OFS    = 'h080,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [PIN_W-1:0]  pad_in_i,
  output logic [PIN_W-1:0]  pad_out_o,
  output logic [PIN_W-1:0]  pad_oe_o,
  output logic [PIN_W-1:0]  gpio_en_o
);
  localparam int unsigned MW_W = 2 * PIN_W;

  sel_e             sel;
  logic             masked;
  logic [PIN_W-1:0] wreg_q [N_WREG];
  logic [PIN_W-1:0] in_q;
  logic [PIN_W-1:0] rd_val;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:MW_W];

  gpio_mw_decode #(.ADDR_W(ADDR_W), .MASK_OFS(MASK_OFS)) u_dec (
    .addr_i  (addr_i),
    .sel_o   (sel),
    .masked_o(masked)
  );

  for (genvar g = 0; g < N_WREG; g++) begin : g_wreg
    gpio_mw_bitreg #(.W(PIN_W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (req_i && we_i && (sel == wreg_sel(g))),
      .masked_i(masked),
      .wdata_i (wdata_i[MW_W-1:0]),
      .q_o     (wreg_q[g])
    );
  end

  gpio_mw_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (in_q)
  );

  always_comb begin
    unique case (sel)
      SEL_MODE: rd_val = wreg_q[0];
      SEL_DIR:  rd_val = wreg_q[1];
      SEL_OUT:  rd_val = wreg_q[2];
      SEL_IN:   rd_val = in_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= DATA_W'(rd_val);
  end

  assign gpio_en_o = wreg_q[0];
  assign pad_oe_o  = wreg_q[1] & wreg_q[0];
  assign pad_out_o = wreg_q[2];
endmodule

// File: rtl/gpio_mw_port_chk.sv
module gpio_mw_port_chk #(
  parameter int unsigned PIN_W       = 8,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned MASK_OFS    = 'h080,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [PIN_W-1:0]  pad_out_o,
  input logic [PIN_W-1:0]  pad_oe_o,
  input logic [PIN_W-1:0]  gpio_en_o
);
  localparam logic [ADDR_W-1:0] P_OUT = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] M_OUT = ADDR_W'(MASK_OFS + 'h020);
  localparam logic [ADDR_W-1:0] P_IN  = ADDR_W'('h030);
  localparam logic [ADDR_W-1:0] M_IN  = ADDR_W'(MASK_OFS + 'h030);

  logic wr, rd;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  // R1
  always @(negedge clk_i)
    if (!rst_ni)
      rst_clear_chk: assert (pad_out_o == '0 && pad_oe_o == '0 &&
                             gpio_en_o == '0 && rdata_o == '0);

  // R2
  plain_out_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == P_OUT |=> pad_out_o == $past(wdata_i[PIN_W-1:0]));

  // R3
  mask_zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == M_OUT && wdata_i[2*PIN_W-1:PIN_W] == '0 |=> $stable(pad_out_o));

  // R6
  in_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && (addr_i == P_IN || addr_i == M_IN)
    |=> $stable(pad_out_o) && $stable(pad_oe_o) && $stable(gpio_en_o));

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));

  // R7
  rd_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (addr_i == P_OUT || addr_i == M_OUT) |=> rdata_o == DATA_W'($past(pad_out_o)));

  // R4
  oe_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && addr_i == ADDR_W'('h000) && wdata_i[PIN_W-1:0] == '0 |=> pad_oe_o == '0);
endmodule

bind gpio_mw_port gpio_mw_port_chk #(
  .PIN_W(PIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .MASK_OFS(MASK_OFS), .SYNC_STAGES(SYNC_STAGES)
) chk_i (.*);

// File: tb/gpio_mw_port_tb_top.sv
module gpio_mw_port_tb_top;
  logic        clk_i  = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i  = 1'b0;
  logic        we_i   = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  pad_in_i = '0;
  logic [7:0]  pad_out_o, pad_oe_o, gpio_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  gpio_mw_port dut_i (.*);

  // behavioural reference
  int m_mode, m_dir, m_out, m_s1, m_s2, m_rd;

  function automatic int ref_read(input int a);
    case (a)
      'h000, 'h080: return m_mode;
      'h010, 'h090: return m_dir;
      'h020, 'h0A0: return m_out;
      'h030, 'h0B0: return m_s2;
      default:      return 0;
    endcase
  endfunction

  function automatic int merge(input int old, input int d, input bit msk);
    int m = msk ? ((d >> 8) & 'hFF) : 'hFF;
    return (old & ~m & 'hFF) | (d & m & 'hFF);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode <= 0; m_dir <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0; m_rd <= 0;
    end else begin
      m_s1 <= int'(pad_in_i);
      m_s2 <= m_s1;
      if (req_i && !we_i) m_rd <= ref_read(int'(addr_i));
      if (req_i && we_i) begin
        case (int'(addr_i))
          'h000: m_mode <= merge(m_mode, int'(wdata_i), 0);
          'h080: m_mode <= merge(m_mode, int'(wdata_i), 1);
          'h010: m_dir  <= merge(m_dir,  int'(wdata_i), 0);
          'h090: m_dir  <= merge(m_dir,  int'(wdata_i), 1);
          'h020: m_out  <= merge(m_out,  int'(wdata_i), 0);
          'h0A0: m_out  <= merge(m_out,  int'(wdata_i), 1);
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check("R4 pad_out", int'(pad_out_o), m_out);
      check("R4 pad_oe", int'(pad_oe_o), m_dir & m_mode);
      check("R4 gpio_en", int'(gpio_en_o), m_mode);
      check("R7 rdata", int'(rdata_o), m_rd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [11:0] a, input string req, input int exp);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    check(req, int'(rdata_o), exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        // R1 reset values
        check("R1 pad_out", int'(pad_out_o), 0);
        check("R1 pad_oe", int'(pad_oe_o), 0);
        check("R1 gpio_en", int'(gpio_en_o), 0);
        check("R1 rdata", int'(rdata_o), 0);
        rst_ni = 1;
        idle(2);
        rd(12'h000, "R1 mode after reset", 0);

        // R2 plain writes
        wr(12'h000, 32'h0000_00FF);
        wr(12'h010, 32'h0000_000F);
        wr(12'h020, 32'h0000_00A5);
        check("R2 out", int'(pad_out_o), 'hA5);
        check("R2 oe", int'(pad_oe_o), 'h0F);

        // R3 masked writes
        wr(12'h0A0, 32'h0000_3CFF);
        check("R3 masked set", int'(pad_out_o), 'hBD);
        wr(12'h0A0, 32'h0000_00FF);
        check("R3 zero mask", int'(pad_out_o), 'hBD);

        // R8 upper data bits
        wr(12'h020, 32'hFFFF_0012);
        check("R8 plain upper", int'(pad_out_o), 'h12);
        wr(12'h0A0, 32'hABCD_0200);
        check("R8 masked upper", int'(pad_out_o), 'h10);

        // R4 mode gates output enable
        wr(12'h080, 32'h0000_0300);
        check("R4 oe gated", int'(pad_oe_o), 'h0C);
        check("R4 en", int'(gpio_en_o), 'hFC);

        // R5 synchronized input
        pad_in_i = 8'h5A;
        idle(3);
        rd(12'h030, "R5 input", 'h5A);
        rd(12'h0B0, "R7 masked input read", 'h5A);
        @(negedge clk_i);
        pad_in_i = 8'hC3;
        req_i = 1; we_i = 0; addr_i = 12'h030;
        @(negedge clk_i);
        req_i = 0;
        check("R5 lag", int'(rdata_o), 'h5A);
        idle(2);
        rd(12'h030, "R5 settled", 'hC3);

        // R6 ignored writes
        wr(12'h030, 32'h0000_00FF);
        wr(12'h0B0, 32'h0000_FFFF);
        wr(12'h040, 32'h0000_00FF);
        wr(12'h0C0, 32'h0000_FFFF);
        check("R6 out kept", int'(pad_out_o), 'h10);
        check("R6 oe kept", int'(pad_oe_o), 'h0C);
        rd(12'h000, "R6 mode kept", 'hFC);

        // R7 read paths
        rd(12'h0A0, "R7 masked out read", 'h10);
        rd(12'h090, "R7 masked dir read", 'h0F);
        rd(12'h040, "R7 unmapped", 0);
        idle(3);
        check("R7 hold", int'(rdata_o), 0);

        // mixed pattern on direction
        wr(12'h090, 32'h0000_F0A0);
        rd(12'h010, "R3 dir masked", 'hAF);
        wr(12'h080, 32'h0000_FFFF);
        check("R4 full mode", int'(pad_oe_o), 'hAF);
        idle(4);
      end
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule